// File: doc/BRIEF.md
# Flash Block Write-Protection Controller

This block sits in front of the program and erase engine of a 4 Mbit, byte-wide flash array (512K bytes) and decides, one request at a time, whether a write-type operation may proceed. The array is divided into eight equal 64 KB blocks. The highest block holds boot code and has its own active-low hardware protect pin. A second active-low pin guards the other seven blocks. Each block also has a software lock bit, written through a small register-write port.

The block works in one of two interface modes, latched while reset is held. In the serial host-bus mode (LPC), the lock bits take part in the decision and a whole-chip erase is never allowed. In the multiplexed-address programmer mode, the lock bits are ignored and a whole-chip erase is allowed when neither hardware pin protects anything. Reads always pass. For each request strobe, the block raises exactly one of two registered flags, grant or deny, on the following clock.

Top module: `flash_wp_ctrl`

## Requirements
- R1: While reset is active, all eight lock bits clear to unlocked and both grant and deny are low.
- R2: The mode input (1 = programmer mode, 0 = LPC mode) is captured on every clock while reset is active and held afterwards. Changes to the mode input outside reset have no effect on decisions.
- R3: The target block of a request is req_addr[18:16]. Block 7 is the boot block.
- R4: While tbl_n is low, every byte program (op 1) or block erase (op 2) to block 7 is denied, whatever the lock bits hold.
- R5: While wp_n is low, every byte program or block erase to blocks 0 to 6 is denied, whatever the lock bits hold.
- R6: In LPC mode, a byte program or block erase to a block whose lock bit is 1 is denied. When the block's pin is high and its lock bit is 0, the request is granted. Lock bit i is written with lock_wdata when lock_we is high and lock_idx = i.
- R7: In programmer mode, the lock bits have no effect. A byte program or block erase is decided by the pins alone.
- R8: A chip erase (op 3) is always denied in LPC mode. In programmer mode it is granted only when both tbl_n and wp_n are high.
- R9: A read (op 0) is always granted.
- R10: Grant and deny are registered. Exactly one of them is high on the cycle after a clock edge that samples req_valid high, and both are low after an edge that samples req_valid low.
- R11: Reset is active while either rst_a_n or rst_b_n is low. Either input alone clears the lock bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_a_n | input | 1 | Active-low reset, first source |
| rst_b_n | input | 1 | Active-low reset, second source |
| mode_sel | input | 1 | Interface mode strap: 1 = programmer mode, 0 = LPC mode |
| tbl_n | input | 1 | Active-low hardware protect for the boot block |
| wp_n | input | 1 | Active-low hardware protect for blocks 0 to 6 |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 read, 1 byte program, 2 block erase, 3 chip erase |
| req_addr | input | 19 | Byte address of the request |
| lock_we | input | 1 | Lock bit write enable |
| lock_idx | input | 3 | Lock bit to write |
| lock_wdata | input | 1 | Value to write (1 = locked) |
| grant | output | 1 | Request allowed (one cycle after strobe) |
| deny | output | 1 | Request refused (one cycle after strobe) |

## Verification
The hardest situations to reach are the ones where the lock bits must be shown to have no effect. These are programmer mode with arbitrary lock patterns, and a mode pin changed after reset. Reaching them needs a reset with the mode strap set, then lock writes, then requests, all in the right order. The bench steps through both modes. In each mode it loads a list of directed and random lock patterns and sweeps every block, pin pair and operation against a reference function. It then toggles the mode pin outside reset and pulses each reset source alone to show what persists and what clears.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_BERASE = 2'd2,
    OP_CERASE = 2'd3
  } wp_op_e;
endpackage

// File: rtl/wp_reset_mode.sv
module wp_reset_mode (
  input  logic clk,
  input  logic rst_a_n,
  input  logic rst_b_n,
  input  logic mode_sel,
  output logic rst,
  output logic prog_mode
);
  assign rst = ~(rst_a_n & rst_b_n);

  always_ff @(posedge clk) begin
    if (rst) prog_mode <= mode_sel;
  end

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(prog_mode));
endmodule

// File: rtl/wp_lock_regs.sv
module wp_lock_regs #(
  parameter int NBLK  = 8,
  localparam int IDXW = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IDXW-1:0] idx,
  input  logic            wdata,
  output logic [NBLK-1:0] locks
);
  for (genvar i = 0; i < NBLK; i++) begin : g_lock
    always_ff @(posedge clk) begin
      if (rst) locks[i] <= 1'b0;
      else if (we && idx == IDXW'(i)) locks[i] <= wdata;
    end
  end

  // R1
  lock_clear_chk: assert property (@(posedge clk)
    rst |=> (locks == '0));
endmodule

// File: rtl/wp_decide.sv
module wp_decide
  import wp_pkg::*;
#(
  parameter int NBLK  = 8,
  localparam int IDXW = $clog2(NBLK)
) (
  input  logic [NBLK-1:0] locks,
  input  logic            prog_mode,
  input  logic            tbl_n,
  input  logic            wp_n,
  input  logic [IDXW-1:0] blk,
  input  wp_op_e          op,
  output logic            allow
);
  logic [NBLK-1:0] pin_prot;
  logic [NBLK-1:0] blk_prot;

  for (genvar i = 0; i < NBLK; i++) begin : g_prot
    if (i == NBLK - 1) begin : g_boot
      assign pin_prot[i] = ~tbl_n;
    end else begin : g_main
      assign pin_prot[i] = ~wp_n;
    end
    assign blk_prot[i] = pin_prot[i] | (~prog_mode & locks[i]);
  end

  always_comb begin
    unique case (op)
      OP_READ:   allow = 1'b1;
      OP_PROG,
      OP_BERASE: allow = ~blk_prot[blk];
      OP_CERASE: allow = prog_mode & ~(|pin_prot);
      default:   allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import wp_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int NBLK   = 8,
  localparam int IDXW  = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst_a_n,
  input  logic              rst_b_n,
  input  logic              mode_sel,
  input  logic              tbl_n,
  input  logic              wp_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              lock_we,
  input  logic [IDXW-1:0]   lock_idx,
  input  logic              lock_wdata,
  output logic              grant,
  output logic              deny
);
  logic            rst;
  logic            prog_mode;
  logic [NBLK-1:0] locks;
  logic            allow;
  logic [IDXW-1:0] blk;
  wp_op_e          op;
  logic            unused_low;

  // R3
  assign blk        = req_addr[ADDR_W-1 -: IDXW];
  assign unused_low = ^req_addr[ADDR_W-IDXW-1:0];
  assign op         = wp_op_e'(req_op);

  wp_reset_mode u_rm (
    .clk(clk), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n),
    .mode_sel(mode_sel), .rst(rst), .prog_mode(prog_mode)
  );

  wp_lock_regs #(.NBLK(NBLK)) u_lk (
    .clk(clk), .rst(rst), .we(lock_we), .idx(lock_idx),
    .wdata(lock_wdata), .locks(locks)
  );

  wp_decide #(.NBLK(NBLK)) u_dc (
    .locks(locks), .prog_mode(prog_mode), .tbl_n(tbl_n), .wp_n(wp_n),
    .blk(blk), .op(op), .allow(allow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= 1'b0;
      deny  <= 1'b0;
    end else begin
      grant <= req_valid & allow;
      deny  <= req_valid & ~allow;
    end
  end

  // R10
  one_flag_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (grant ^ deny));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!grant && !deny));
  // R4
  boot_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !tbl_n && blk == IDXW'(NBLK-1) &&
     (req_op == 2'd1 || req_op == 2'd2)) |=> deny);
  // R5
  main_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !wp_n && blk != IDXW'(NBLK-1) &&
     (req_op == 2'd1 || req_op == 2'd2)) |=> deny);
  // R8
  chip_lpc_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !prog_mode && req_op == 2'd3) |=> deny);
  // R9
  read_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'd0) |=> grant);
endmodule

// File: tb/sim_flash_wp_ctrl.sv
module sim_flash_wp_ctrl;
  logic clk = 1'b0;
  logic rst_a_n = 1'b0, rst_b_n = 1'b0, mode_sel = 1'b0;
  logic tbl_n = 1'b1, wp_n = 1'b1, req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [18:0] req_addr = '0;
  logic lock_we = 1'b0, lock_wdata = 1'b0;
  logic [2:0] lock_idx = '0;
  logic grant, deny;
  int checks = 0, errors = 0;
  logic [7:0] mdl_locks;
  logic mdl_mode;
  int seed_dummy;

  always #10 clk = ~clk;

  flash_wp_ctrl u0 (.*);

  function automatic logic ref_allow(logic mode, logic [7:0] lk,
      logic tb, logic wp, logic [2:0] b, logic [1:0] op);
    logic pp;
    pp = (b == 3'd7) ? !tb : !wp;
    case (op)
      2'd0: return 1'b1;
      2'd3: return mode && tb && wp;
      default: return !(pp || (!mode && lk[b]));
    endcase
  endfunction

  function automatic string tag(logic mode, logic [7:0] lk,
      logic tb, logic wp, logic [2:0] b, logic [1:0] op);
    if (op == 2'd0) return "R9";
    if (op == 2'd3) return "R8";
    if (b == 3'd7 && !tb) return "R4";
    if (b != 3'd7 && !wp) return "R5";
    if (mode) return "R7";
    return (lk[b]) ? "R6" : "R6/R3";
  endfunction

  task automatic chk(string t, logic g, logic d, logic eg, logic ed);
    checks++;
    if (g !== eg || d !== ed) begin
      errors++;
      $display("FAIL %s grant=%b deny=%b expected grant=%b deny=%b",
               t, g, d, eg, ed);
    end
  endtask

  task automatic do_reset(logic m);
    @(negedge clk);
    mode_sel = m; rst_a_n = 0; rst_b_n = 0;
    repeat (2) @(negedge clk);
    chk("R1", grant, deny, 1'b0, 1'b0);
    rst_a_n = 1; rst_b_n = 1;
    mdl_mode = m; mdl_locks = '0;
  endtask

  task automatic write_locks(logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      lock_we = 1; lock_idx = 3'(i); lock_wdata = v[i];
      @(negedge clk);
    end
    lock_we = 0;
    mdl_locks = v;
  endtask

  task automatic request(logic tb, logic wp, logic [2:0] b, logic [1:0] op);
    logic e;
    tbl_n = tb; wp_n = wp; req_op = op;
    req_addr = {b, 16'($urandom)};
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    e = ref_allow(mdl_mode, mdl_locks, tb, wp, b, op);
    chk(tag(mdl_mode, mdl_locks, tb, wp, b, op), grant, deny, e, !e);
  endtask

  initial begin
    logic [7:0] pats [0:11];
    seed_dummy = $urandom(32'h5eed1234);
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h80; pats[3] = 8'h7F;
    for (int i = 4; i < 12; i++) pats[i] = 8'($urandom);
    for (int m = 0; m < 2; m++) begin
      do_reset(1'(m));
      for (int p = 0; p < 12; p++) begin
        write_locks(pats[p]);
        for (int b = 0; b < 8; b++)
          for (int pin = 0; pin < 4; pin++)
            for (int op = 0; op < 4; op++)
              request(pin[1], pin[0], 3'(b), 2'(op));
      end
      for (int k = 0; k < 1500; k++) begin
        if ((k % 50) == 0) write_locks(8'($urandom));
        request(1'($urandom), 1'($urandom), 3'($urandom), 2'($urandom));
      end
    end
    // R10: no strobe, no flags
    @(negedge clk);
    chk("R10", grant, deny, 1'b0, 1'b0);
    // R2: LPC latched, mode pin flipped afterwards
    do_reset(1'b0);
    write_locks(8'hFF);
    mode_sel = 1'b1;
    request(1'b1, 1'b1, 3'd0, 2'd3);
    request(1'b1, 1'b1, 3'd2, 2'd1);
    chk("R2", deny, grant, 1'b1, 1'b0);
    // R11: each reset source alone clears locks
    @(negedge clk); rst_a_n = 0; @(negedge clk); rst_a_n = 1;
    mdl_locks = '0; mdl_mode = 1'b1;
    request(1'b1, 1'b1, 3'd3, 2'd1);
    chk("R11", grant, deny, 1'b1, 1'b0);
    write_locks(8'hFF);
    mode_sel = 1'b0;
    @(negedge clk); rst_b_n = 0; @(negedge clk); rst_b_n = 1;
    mdl_locks = '0; mdl_mode = 1'b0;
    request(1'b1, 1'b1, 3'd5, 2'd2);
    chk("R11", grant, deny, 1'b1, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog grant=%b deny=%b expected run to end", grant, deny);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule